// File: doc/BRIEF.md
# Multicycle 32-bit RISC Core

This block is a small 32-bit processor that runs one instruction at a time through a short sequence of phases: fetch, register read, execute, memory and write-back. It supports seven instructions in the usual 32-bit three-register and immediate encodings: add, add-immediate, and-immediate, load word, store word, branch-if-not-equal and jump. It holds thirty-two 32-bit general registers. The register file is read and written only on a clock edge, so every instruction spends one cycle reading its operands. An instruction passes through only the phases it needs.

The core talks to a single external memory of 32-bit words. One shared 32-bit bidirectional bus carries both instruction fetches and data. Addresses are word indices, so the program counter and the load and store addresses step by one per word. The memory port has no valid/ready handshake and no back-pressure. In a cycle with `mem_cs` high and `mem_we` low, the memory must place the addressed word on the bus within the same cycle, and the core samples it at the next rising edge. In a cycle with `mem_cs` and `mem_we` both high, the core drives the bus, and the memory captures the word at that edge. In every other cycle the core leaves the bus at high impedance.

Top module: `mc_risc_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the program counter and all registers to zero. While reset is held, and in the cycle after it is released, the core presents a fetch of word 0 (`mem_cs`=1, `mem_we`=0, `mem_addr`=0).
- R2: `mem_cs` is high only in fetch cycles and memory cycles. `mem_we` is high only in the memory cycle of a store. The register-read, execute and write-back cycles show `mem_cs`=0.
- R3: Each fetch reads the word at the program counter, and the next sequential fetch address is that value plus 1. Cycle counts from fetch to the next fetch: add, add-immediate and and-immediate take 4, load takes 5, store takes 4, and branch, jump and unsupported codes take 3.
- R4: add has opcode bits[31:26]=0x00 and function bits[5:0]=0x20. It writes rs (bits[25:21]) + rt (bits[20:16]), modulo 2^32, to rd (bits[15:11]).
- R5: add-immediate has opcode 0x08. It writes rs + the sign-extended bits[15:0] to rt.
- R6: and-immediate has opcode 0x0C. It writes rs AND the zero-extended bits[15:0] to rt.
- R7: load has opcode 0x23. Its memory cycle reads word address rs + the sign-extended offset, and the word read is written to rt.
- R8: store has opcode 0x2B. Its memory cycle drives the value of rt on the bus, with `mem_we`=1, at word address rs + the sign-extended offset.
- R9: branch-if-not-equal has opcode 0x05. When rs differs from rt, the next fetch is at (address of the branch + 1) + the sign-extended offset. Otherwise the next fetch is at the branch address + 1.
- R10: jump has opcode 0x02. The next fetch is at bits[25:0] of the instruction, zero-extended and used as a word address.
- R11: Register 0 always reads as zero. Writes to register 0 have no effect.
- R12: Any other opcode, and an opcode-0x00 word whose function field is not 0x20, acts as a no-op. It writes no register and advances to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_cs | output | 1 | Memory select for a fetch or a data access |
| mem_we | output | 1 | Write strobe, high only in a store's memory cycle |
| mem_addr | output | 32 | Word address of the access |
| mem_data | inout | 32 | Shared bus: memory drives it on reads, the core drives it on stores |

## Verification
Registers can only be seen at the ports through the stores that leave the core, and through the addresses that loads and stores present. A corrupted register therefore shows up at the first store of that register or the first access based on it. That can be many instructions later, so every program ends with a store of each register in use. A wrong program counter or phase shows up within one cycle as a bus cycle with the wrong select, strobe or address, because every cycle is compared against a bench model running in lockstep. A register-file read of register 0 that returns anything but zero is flagged in the very next cycle.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;
  localparam int WORD_W   = 32;
  localparam int SEL_W    = 5;
  localparam int RD_PORTS = 2;

  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_JUMP    = 6'h02;
  localparam logic [5:0] OPC_BNE     = 6'h05;
  localparam logic [5:0] OPC_ADDI    = 6'h08;
  localparam logic [5:0] OPC_ANDI    = 6'h0C;
  localparam logic [5:0] OPC_LOAD    = 6'h23;
  localparam logic [5:0] OPC_STORE   = 6'h2B;
  localparam logic [5:0] FN_ADD      = 6'h20;

  typedef enum logic [2:0] {
    PH_FETCH, PH_REGRD, PH_EXEC, PH_MEM, PH_WB
  } phase_e;

  typedef enum logic [2:0] {
    IK_ADD, IK_ADDI, IK_ANDI, IK_LOAD, IK_STORE, IK_BNE, IK_JUMP, IK_NOP
  } ikind_e;

  typedef enum logic {ALU_ADD, ALU_AND} aluop_e;

  typedef struct packed {
    logic [5:0]       opc;
    logic [SEL_W-1:0] rs;
    logic [SEL_W-1:0] rt;
    logic [SEL_W-1:0] rd;
    logic [4:0]       sh;
    logic [5:0]       fn;
  } iword_t;

  function automatic ikind_e classify(input iword_t w);
    ikind_e k;
    case (w.opc)
      OPC_SPECIAL: k = (w.fn == FN_ADD) ? IK_ADD : IK_NOP;
      OPC_ADDI:    k = IK_ADDI;
      OPC_ANDI:    k = IK_ANDI;
      OPC_LOAD:    k = IK_LOAD;
      OPC_STORE:   k = IK_STORE;
      OPC_BNE:     k = IK_BNE;
      OPC_JUMP:    k = IK_JUMP;
      default:     k = IK_NOP;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_core_pkg::*;
#(
  parameter int DW    = WORD_W,
  parameter int COUNT = 32,
  localparam int AW   = $clog2(COUNT)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         re,
  input  logic [RD_PORTS-1:0][AW-1:0]  ra,
  output logic [RD_PORTS-1:0][DW-1:0]  rq,
  input  logic                         we,
  input  logic [AW-1:0]                wa,
  input  logic [DW-1:0]                wd
);
  logic [DW-1:0] bank [COUNT];

  // write port: entry 0 is never stored
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < COUNT; i++) bank[i] <= '0;
    end else if (we && wa != '0) begin
      bank[wa] <= wd;
    end
  end

  // registered read ports, entry 0 forced to zero
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)     rq[p] <= '0;
      else if (re) rq[p] <= (ra[p] == '0) ? '0 : bank[ra[p]];
    end
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_core_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  aluop_e        op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          same
);
  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      default: y = a + b;
    endcase
    same = (a == b);
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_core_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ikind_e kind,
  input  logic   operands_same,
  output phase_e phase,
  output logic   ir_ld,
  output logic   pc_inc,
  output logic   rf_re,
  output logic   alu_ld,
  output logic   pc_branch,
  output logic   pc_jump,
  output logic   bus_cs,
  output logic   bus_we,
  output logic   mdr_ld,
  output logic   rf_we
);
  phase_e nxt;

  always_comb begin
    nxt = PH_FETCH;
    unique case (phase)
      PH_FETCH: nxt = PH_REGRD;
      PH_REGRD: nxt = PH_EXEC;
      PH_EXEC: begin
        unique case (kind)
          IK_ADD, IK_ADDI, IK_ANDI: nxt = PH_WB;
          IK_LOAD, IK_STORE:        nxt = PH_MEM;
          default:                  nxt = PH_FETCH;
        endcase
      end
      PH_MEM:  nxt = (kind == IK_LOAD) ? PH_WB : PH_FETCH;
      default: nxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= nxt;
  end

  always_comb begin
    ir_ld     = (phase == PH_FETCH);
    pc_inc    = (phase == PH_FETCH);
    rf_re     = (phase == PH_REGRD);
    alu_ld    = (phase == PH_EXEC);
    pc_branch = (phase == PH_EXEC) && (kind == IK_BNE) && !operands_same;
    pc_jump   = (phase == PH_EXEC) && (kind == IK_JUMP);
    bus_cs    = (phase == PH_FETCH) || (phase == PH_MEM);
    bus_we    = (phase == PH_MEM) && (kind == IK_STORE);
    mdr_ld    = (phase == PH_MEM) && (kind == IK_LOAD);
    rf_we     = (phase == PH_WB);
  end
endmodule

// File: rtl/mc_risc_core.sv
module mc_risc_core
  import mc_core_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_COUNT = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_cs,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [WORD_W-1:0] mem_data
);
  localparam int RSEL_W = $clog2(REG_COUNT);
  localparam int HALF_W = WORD_W / 2;
  localparam int JMP_W  = 26;

  logic [ADDR_W-1:0] pc;
  iword_t            ir;
  logic [WORD_W-1:0] alu_q, mdr;
  logic [WORD_W-1:0] rs_val, rt_val;
  logic [WORD_W-1:0] imm_sx, imm_zx, alu_b, alu_y;
  logic              same;
  ikind_e            kind;
  phase_e            phase;
  aluop_e            aop;
  logic ir_ld, pc_inc, rf_re, alu_ld, pc_branch, pc_jump;
  logic bus_cs, bus_we, mdr_ld, rf_we;
  logic [RD_PORTS-1:0][RSEL_W-1:0] rsel;
  logic [RD_PORTS-1:0][WORD_W-1:0] rval;
  logic [RSEL_W-1:0] wsel;
  logic [WORD_W-1:0] wval;

  assign kind   = classify(ir);
  assign imm_sx = {{HALF_W{ir[HALF_W-1]}}, ir[HALF_W-1:0]};
  assign imm_zx = {{HALF_W{1'b0}}, ir[HALF_W-1:0]};

  mc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .kind(kind), .operands_same(same), .phase(phase),
    .ir_ld(ir_ld), .pc_inc(pc_inc), .rf_re(rf_re), .alu_ld(alu_ld),
    .pc_branch(pc_branch), .pc_jump(pc_jump), .bus_cs(bus_cs),
    .bus_we(bus_we), .mdr_ld(mdr_ld), .rf_we(rf_we)
  );

  assign rsel[0] = RSEL_W'(ir.rs);
  assign rsel[1] = RSEL_W'(ir.rt);
  assign rs_val  = rval[0];
  assign rt_val  = rval[1];
  assign wsel    = (kind == IK_ADD) ? RSEL_W'(ir.rd) : RSEL_W'(ir.rt);
  assign wval    = (kind == IK_LOAD) ? mdr : alu_q;

  mc_regfile #(.DW(WORD_W), .COUNT(REG_COUNT)) u_rf (
    .clk(clk), .rst(rst), .re(rf_re), .ra(rsel), .rq(rval),
    .we(rf_we), .wa(wsel), .wd(wval)
  );

  always_comb begin
    unique case (kind)
      IK_ADD, IK_BNE: alu_b = rt_val;
      IK_ANDI:        alu_b = imm_zx;
      default:        alu_b = imm_sx;
    endcase
    aop = (kind == IK_ANDI) ? ALU_AND : ALU_ADD;
  end

  mc_alu #(.DW(WORD_W)) u_alu (
    .op(aop), .a(rs_val), .b(alu_b), .y(alu_y), .same(same)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      alu_q <= '0;
      mdr   <= '0;
    end else begin
      if (ir_ld)  ir <= iword_t'(mem_data);
      if (alu_ld) alu_q <= alu_y;
      if (mdr_ld) mdr <= mem_data;
      if (pc_inc)         pc <= pc + 1'b1;
      else if (pc_jump)   pc <= ADDR_W'(ir[JMP_W-1:0]);
      else if (pc_branch) pc <= pc + ADDR_W'(imm_sx);
    end
  end

  assign mem_cs   = bus_cs;
  assign mem_we   = bus_we;
  assign mem_addr = (phase == PH_MEM) ? ADDR_W'(alu_q) : pc;
  assign mem_data = bus_we ? rt_val : 'z;
endmodule

// File: rtl/mc_risc_core_chk.sv
module mc_risc_core_chk
  import mc_core_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input phase_e            phase,
  input logic [SEL_W-1:0]  rs_sel,
  input logic [WORD_W-1:0] rs_val
);
  AST_RESET_FETCH: assert property (@(posedge clk)
    rst |=> (cs && !we && addr == '0)); // R1

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    we |-> cs); // R2

  AST_READ_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cs && !we) |=> !cs); // R3

  AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (cs && we) |=> (cs && !we)); // R3

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REGRD && rs_sel == '0) |=> (rs_val == '0)); // R11
endmodule

bind mc_risc_core mc_risc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs(mem_cs), .we(mem_we), .addr(mem_addr),
  .phase(phase), .rs_sel(ir.rs), .rs_val(rs_val)
);

// File: tb/sim_mc_risc_core.sv
module sim_mc_risc_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 128;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs, we;
  logic [31:0] addr;
  wire  [31:0] bus;

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] mm  [MEM_WORDS];
  logic [31:0] rf  [32];
  string       src [32];
  logic [31:0] pc;
  string       ftag;
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_risc_core u0 (.clk(clk), .rst(rst), .mem_cs(cs), .mem_we(we),
                   .mem_addr(addr), .mem_data(bus));

  assign bus = (cs && !we) ? mem[addr[6:0]] : 'z;
  always @(posedge clk) if (cs && we) mem[addr[6:0]] <= bus;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cmp(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [31:0] w);
    return {{16{w[15]}}, w[15:0]};
  endfunction

  function automatic logic [31:0] rand_ins();
    logic [4:0]  rs = 5'($urandom_range(0, 7));
    logic [4:0]  rt = 5'($urandom_range(0, 7));
    logic [4:0]  rd = 5'($urandom_range(0, 7));
    logic [15:0] im = 16'($urandom_range(0, 65535));
    logic [5:0]  op;
    logic [5:0]  fn;
    int          sel = $urandom_range(0, 15);
    if (sel <= 2) return {6'h00, rs, rt, rd, 5'd0, 6'h20};
    if (sel <= 4) return {6'h08, rs, rt, im};
    if (sel == 5) return {6'h0C, rs, rt, im};
    if (sel <= 7) return {6'h23, rs, rt, im};
    if (sel <= 10) return {6'h2B, rs, rt, im};
    if (sel <= 12) return {6'h05, rs, rt, 16'($signed($urandom_range(0, 16)) - 8)};
    if (sel == 13) return {6'h02, 26'($urandom)};
    if (sel == 14) begin
      do op = 6'($urandom_range(0, 63));
      while (op inside {6'h00, 6'h02, 6'h05, 6'h08, 6'h0C, 6'h23, 6'h2B});
      return {op, 26'($urandom)};
    end
    do fn = 6'($urandom_range(0, 63)); while (fn == 6'h20);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic wr(input logic [4:0] r, input logic [31:0] v, input string t);
    if (r != 5'd0) begin
      rf[r]  = v;
      src[r] = t;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      cmp("R2", "select low", {63'd0, cs}, 64'd0);
      @(negedge clk);
    end
  endtask

  // one instruction in lockstep; entered at the negedge of its fetch cycle
  task automatic exec_one();
    logic [31:0] ins, ea, npc;
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd;
    ins = mm[pc[6:0]];
    cmp(ftag, "fetch", {30'd0, cs, we, addr}, {30'd0, 1'b1, 1'b0, pc});
    @(negedge clk);
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    npc  = pc + 1;
    ftag = "R3";
    ea   = rf[rs] + sx(ins);
    idle(2);
    if (op == 6'h00 && ins[5:0] == 6'h20) begin
      idle(1); wr(rd, rf[rs] + rf[rt], "R4");
    end else if (op == 6'h08) begin
      idle(1); wr(rt, ea, "R5");
    end else if (op == 6'h0C) begin
      idle(1); wr(rt, rf[rs] & {16'd0, ins[15:0]}, "R6");
    end else if (op == 6'h23) begin
      cmp("R7", "load access", {30'd0, cs, we, addr}, {30'd0, 1'b1, 1'b0, ea});
      @(negedge clk);
      idle(1); wr(rt, mm[ea[6:0]], "R7");
    end else if (op == 6'h2B) begin
      cmp("R8", "store access", {30'd0, cs, we, addr}, {30'd0, 1'b1, 1'b1, ea});
      cmp(src[rt], "stored value", {32'd0, bus}, {32'd0, rf[rt]});
      @(negedge clk);
      mm[ea[6:0]] = rf[rt];
    end else if (op == 6'h05) begin
      if (rf[rs] != rf[rt]) npc = npc + sx(ins);
      ftag = "R9";
    end else if (op == 6'h02) begin
      npc = {6'd0, ins[25:0]};
      ftag = "R10";
    end else begin
      ftag = "R12";
    end
    pc = npc;
  endtask

  // reset (R1) with the given image loaded; leaves the bench at the first fetch
  task automatic start_prog(input int skew);
    repeat (skew) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    cmp("R1", "reset fetch", {30'd0, cs, we, addr}, 64'h2_0000_0000);
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = mm[i];
    for (int i = 0; i < 32; i++) begin
      rf[i]  = 32'd0;
      src[i] = (i == 0) ? "R11" : "R1";
    end
    pc   = 32'd0;
    ftag = "R1";
    @(negedge clk);
    cmp("R1", "reset fetch", {30'd0, cs, we, addr}, 64'h2_0000_0000);
    rst = 1'b0;
  endtask

  // append stores of registers 0..7 at the current fetch point
  task automatic dump_regs();
    for (int i = 0; i < 8; i++) begin
      logic [31:0] slot = (pc + 32'(i)) & 32'h7F;
      logic [31:0] w    = 32'hAC00_0000 | (32'(i) << 16) | slot;
      mm[slot[6:0]]  = w;
      mem[slot[6:0]] = w;
    end
    for (int i = 0; i < 8; i++) exec_one();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed image: sign/zero extension, reg 0, negative offset, branches, jump, no-ops
    for (int i = 0; i < MEM_WORDS; i++) mm[i] = 32'h1000_0000 + 32'(i);
    mm[0]  = 32'h2002_0005;  // addi $2,$0,5          R5
    mm[1]  = 32'h2003_FFFF;  // addi $3,$0,-1         R5
    mm[2]  = 32'h3064_8001;  // andi $4,$3,0x8001     R6
    mm[3]  = 32'h0043_2820;  // add  $5,$2,$3         R4
    mm[4]  = 32'h2040_0007;  // addi $0,$2,7          R11
    mm[5]  = 32'hAC00_0064;  // sw $0,100($0)         R11
    mm[6]  = 32'h8CA6_0040;  // lw $6,64($5)          R7
    mm[7]  = 32'hAC46_005A;  // sw $6,90($2)          R8
    mm[8]  = 32'h8C47_FFFF;  // lw $7,-1($2)          R7
    mm[9]  = 32'h1442_0005;  // bne $2,$2 not taken   R9
    mm[10] = 32'h14A2_0002;  // bne $5,$2 taken -> 13 R9
    mm[13] = 32'h0800_000E;  // j 14                  R10
    mm[14] = 32'hAC05_006E;  // sw $5
    mm[15] = 32'hAC04_006F;  // sw $4
    mm[16] = 32'hAC03_0070;  // sw $3
    mm[17] = 32'hAC07_0071;  // sw $7
    mm[18] = 32'h0800_0014;  // j 20
    mm[20] = 32'h0043_2822;  // unsupported function  R12
    mm[21] = 32'hFC00_0000;  // unsupported opcode    R12
    mm[22] = 32'h0800_0000;  // j 0
    mm[68] = 32'hCAFE_1234;
    start_prog(0);
    for (int n = 0; n < 45; n++) exec_one();
    dump_regs();

    // constrained random images, some with reset applied mid-instruction
    for (int p = 0; p < 10; p++) begin
      for (int i = 0; i < MEM_WORDS; i++) mm[i] = rand_ins();
      start_prog(p % 3);
      for (int n = 0; n < 150; n++) exec_one();
      dump_regs();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule